// File: doc/BRIEF.md
# Two-Pass EPROM Programming Sequencer

This controller writes a complete image into an external UV-erasable EPROM through a simple programmer interface. It works in three stages. The first stage fires one program pulse at every location in ascending order and reads nothing back. The second stage returns to location zero and reads each byte at the elevated programming level. When a byte does not match, the controller pulses that byte again, up to a fixed limit. The third stage checks the whole array twice at normal operating levels, first at the low corner and then at the high corner.

The desired byte for the current address comes combinationally from a source buffer, which is addressed by the same address output. The controller drives a program strobe, a 2-bit supply-level code and the address. It samples the device read data a fixed number of cycles after the address settles. When it finishes, it holds a pass/fail result and the total number of extra pulses. On failure it also holds the address and stage where the first failure occurred. All of these stay valid until the next start.

Top module: `eprom_burn_seq`

## Requirements
- R1: `start_i` is acted on only while `busy_o` is low. A start clears `done_o` and raises `busy_o` on the next cycle. A start while busy changes nothing. After completion, `done_o`, `pass_o`, `fail_addr_o`, `fail_phase_o` and `repair_cnt_o` hold their values until the next accepted start.
- R2: The first stage applies exactly one program pulse to each address, in order from 0 up to 2^ADDR_W-1, before any further pulse is issued.
- R3: Every program pulse keeps `pgm_o` high for exactly (CLK_HZ/1000000)*PULSE_US cycles, which is 100 cycles with the defaults. `vsel_o` is 2'b01 (elevated programming level) whenever `pgm_o` is high.
- R4: The repair stage starts at address 0 and compares each byte at level 2'b01. On a mismatch it re-pulses the same address and reads it again. It moves to the next address only after a match. A read never counts as a pulse, so the total pulse count equals 2^ADDR_W plus `repair_cnt_o`.
- R5: One address may receive at most MAX_REPAIR (10) re-pulses in the repair stage. A mismatch on the read after the last allowed re-pulse ends the run with `pass_o`=0, `fail_phase_o`=2'd0 and `fail_addr_o` set to that address.
- R6: The final stage verifies every address at level 2'b10 (low corner) and then at level 2'b11 (high corner). The first mismatch ends the run with `fail_phase_o`=2'd1 (low) or 2'd2 (high) and that address. If every location passes, `pass_o`=1.
- R7: After any change of `vsel_o`, at least SETTLE_CYC cycles elapse before a pulse starts or read data is sampled.
- R8: Read data is sampled ACCESS_CYC cycles after the address last changed, and never earlier.
- R9: `repair_cnt_o` equals the number of re-pulses applied in the repair stage of the current run. It is zero right after an accepted start and never decreases within a run.
- R10: While idle, `vsel_o` is 2'b00 and `pgm_o` is low. After reset, `busy_o`, `done_o` and `pass_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| addr_o | output | ADDR_W | Device and source-buffer address |
| src_data_i | input | DATA_W | Desired byte for `addr_o` |
| wdata_o | output | DATA_W | Data presented to the device for programming |
| rdata_i | input | DATA_W | Device read data |
| pgm_o | output | 1 | Program pulse strobe |
| vsel_o | output | 2 | Supply level: 00 idle, 01 program, 10 verify low, 11 verify high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Run finished, held |
| pass_o | output | 1 | Run passed, held |
| fail_addr_o | output | ADDR_W | Address of the first failure |
| fail_phase_o | output | 2 | Stage of the first failure: 0 repair, 1 low verify, 2 high verify |
| repair_cnt_o | output | CNT_W | Total re-pulses in the repair stage |

## Verification
The assertions assume that `start_i` is a clean one-cycle request and that the source buffer returns a stable byte for a stable address. They assume nothing about the device, because the sequencer's level and timing rules must hold whatever data comes back. The bench's device model returns inverted data whenever the address or level has not been stable for the required time. Any early sample therefore turns into an extra repair or a failure that the checks can see. Random per-address pulse needs are kept in the range 1 to 12, and margin faults are kept sparse, so every stage runs to completion in most cases.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

    typedef enum logic [1:0] {
        VS_IDLE  = 2'b00,
        VS_PROG  = 2'b01,
        VS_VLOW  = 2'b10,
        VS_VHIGH = 2'b11
    } vsel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_PULSE,
        ST_READ,
        ST_STEP
    } state_e;

    typedef enum logic [1:0] {
        PH_PROG,
        PH_REPAIR,
        PH_VLOW,
        PH_VHIGH
    } phase_e;

    localparam logic [1:0] FAIL_REPAIR = 2'd0;
    localparam logic [1:0] FAIL_VLOW   = 2'd1;
    localparam logic [1:0] FAIL_VHIGH  = 2'd2;

endpackage

// File: rtl/eprom_seq_timer.sv
module eprom_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/eprom_repair_track.sv
module eprom_repair_track #(
    parameter int TRY_W      = 4,
    parameter int CNT_W      = 16,
    parameter int MAX_REPAIR = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all_i,
    input  logic             clr_loc_i,
    input  logic             bump_i,
    output logic             at_limit_o,
    output logic [CNT_W-1:0] total_o
);
    typedef struct packed {
        logic [TRY_W-1:0] tries;
        logic [CNT_W-1:0] total;
    } trk_t;

    trk_t d, q;

    always_comb begin
        d = q;
        if (clr_all_i) begin
            d.tries = '0;
            d.total = '0;
        end else if (clr_loc_i) begin
            d.tries = '0;
        end else if (bump_i) begin
            d.tries = q.tries + TRY_W'(1);
            d.total = q.total + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign at_limit_o = (q.tries == TRY_W'(MAX_REPAIR));
    assign total_o    = q.total;
endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
    import eprom_seq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int CLK_HZ     = 1000000,
    parameter int PULSE_US   = 100,
    parameter int SETTLE_CYC = 6,
    parameter int ACCESS_CYC = 3,
    parameter int MAX_REPAIR = 10,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] addr_o,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [DATA_W-1:0] wdata_o,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              pgm_o,
    output logic [1:0]        vsel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [1:0]        fail_phase_o,
    output logic [CNT_W-1:0]  repair_cnt_o
);
    localparam int PULSE_CYC = (CLK_HZ / 1000000) * PULSE_US;
    localparam int TMR_W     = $clog2(PULSE_CYC + SETTLE_CYC + ACCESS_CYC + 2);
    localparam int TRY_W     = $clog2(MAX_REPAIR + 1) + 1;
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [TMR_W-1:0]  T_PULSE   = TMR_W'(PULSE_CYC);
    localparam logic [TMR_W-1:0]  T_SETTLE  = TMR_W'(SETTLE_CYC);
    localparam logic [TMR_W-1:0]  T_ACCESS  = TMR_W'(ACCESS_CYC);

    typedef struct packed {
        state_e            st;
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        vsel_e             vs;
        logic              done;
        logic              pass;
        logic [ADDR_W-1:0] faddr;
        logic [1:0]        fph;
    } seq_t;

    seq_t d, q;

    logic             t_load;
    logic [TMR_W-1:0] t_len;
    logic             t_exp;
    logic             clr_all, clr_loc, bump, at_limit;
    logic             match;

    eprom_seq_timer #(.W(TMR_W)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (t_load),
        .len_i    (t_len),
        .expired_o(t_exp)
    );

    eprom_repair_track #(
        .TRY_W     (TRY_W),
        .CNT_W     (CNT_W),
        .MAX_REPAIR(MAX_REPAIR)
    ) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all_i (clr_all),
        .clr_loc_i (clr_loc),
        .bump_i    (bump),
        .at_limit_o(at_limit),
        .total_o   (repair_cnt_o)
    );

    assign match = (rdata_i == src_data_i);

    always_comb begin
        d       = q;
        t_load  = 1'b0;
        t_len   = '0;
        clr_all = 1'b0;
        clr_loc = 1'b0;
        bump    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_SETTLE;
                    d.ph    = PH_PROG;
                    d.addr  = '0;
                    d.vs    = VS_PROG;
                    d.done  = 1'b0;
                    d.pass  = 1'b0;
                    d.faddr = '0;
                    d.fph   = '0;
                    t_load  = 1'b1;
                    t_len   = T_SETTLE;
                    clr_all = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (q.ph == PH_PROG) begin
                        d.st  = ST_PULSE;
                        t_len = T_PULSE;
                    end else begin
                        d.st  = ST_READ;
                        t_len = T_ACCESS;
                    end
                end
            end
            ST_PULSE: begin
                if (t_exp) begin
                    if (q.ph == PH_PROG) begin
                        d.st = ST_STEP;
                    end else begin
                        d.st   = ST_READ;
                        t_load = 1'b1;
                        t_len  = T_ACCESS;
                    end
                end
            end
            ST_READ: begin
                if (t_exp) begin
                    if (match) begin
                        d.st = ST_STEP;
                    end else if (q.ph == PH_REPAIR && !at_limit) begin
                        d.st   = ST_PULSE;
                        bump   = 1'b1;
                        t_load = 1'b1;
                        t_len  = T_PULSE;
                    end else begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.pass  = 1'b0;
                        d.vs    = VS_IDLE;
                        d.faddr = q.addr;
                        d.fph   = (q.ph == PH_REPAIR) ? FAIL_REPAIR :
                                  (q.ph == PH_VLOW)   ? FAIL_VLOW : FAIL_VHIGH;
                    end
                end
            end
            ST_STEP: begin
                clr_loc = 1'b1;
                t_load  = 1'b1;
                if (q.addr == LAST_ADDR) begin
                    d.addr = '0;
                    case (q.ph)
                        PH_PROG: begin
                            d.ph  = PH_REPAIR;
                            d.st  = ST_READ;
                            t_len = T_ACCESS;
                        end
                        PH_REPAIR: begin
                            d.ph  = PH_VLOW;
                            d.vs  = VS_VLOW;
                            d.st  = ST_SETTLE;
                            t_len = T_SETTLE;
                        end
                        PH_VLOW: begin
                            d.ph  = PH_VHIGH;
                            d.vs  = VS_VHIGH;
                            d.st  = ST_SETTLE;
                            t_len = T_SETTLE;
                        end
                        default: begin
                            d.st   = ST_IDLE;
                            d.vs   = VS_IDLE;
                            d.done = 1'b1;
                            d.pass = 1'b1;
                            t_load = 1'b0;
                        end
                    endcase
                end else begin
                    d.addr = q.addr + ADDR_W'(1);
                    if (q.ph == PH_PROG) begin
                        d.st  = ST_PULSE;
                        t_len = T_PULSE;
                    end else begin
                        d.st  = ST_READ;
                        t_len = T_ACCESS;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.vs <= VS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign addr_o       = q.addr;
    assign wdata_o      = src_data_i;
    assign pgm_o        = (q.st == ST_PULSE);
    assign vsel_o       = q.vs;
    assign busy_o       = (q.st != ST_IDLE);
    assign done_o       = q.done;
    assign pass_o       = q.pass;
    assign fail_addr_o  = q.faddr;
    assign fail_phase_o = q.fph;
endmodule

// File: rtl/eprom_burn_seq_chk.sv
module eprom_burn_seq_chk #(
    parameter int ADDR_W     = 4,
    parameter int CLK_HZ     = 1000000,
    parameter int PULSE_US   = 100,
    parameter int SETTLE_CYC = 6,
    parameter int CNT_W      = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              pgm_o,
    input logic [1:0]        vsel_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              pass_o,
    input logic [ADDR_W-1:0] fail_addr_o,
    input logic [1:0]        fail_phase_o,
    input logic [CNT_W-1:0]  repair_cnt_o
);
    localparam int PULSE_CYC = (CLK_HZ / 1000000) * PULSE_US;

    logic [31:0] width_q;
    logic [15:0] age_q;
    logic [1:0]  vprev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            age_q   <= '0;
            vprev_q <= 2'b00;
        end else begin
            width_q <= pgm_o ? width_q + 32'd1 : 32'd0;
            vprev_q <= vsel_o;
            if (vsel_o != vprev_q)   age_q <= '0;
            else if (age_q != '1)    age_q <= age_q + 16'd1;
        end
    end

    p_pgm_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_o |-> vsel_o == 2'b01);

    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgm_o) |-> width_q == 32'(PULSE_CYC));

    p_settle_before_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgm_o) |-> age_q >= 16'(SETTLE_CYC - 1));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (vsel_o == 2'b00 && !pgm_o));

    p_result_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i && !busy_o) |=> (done_o && $stable(pass_o) &&
            $stable(fail_addr_o) && $stable(fail_phase_o) && $stable(repair_cnt_o)));

    p_repair_monotonic_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> repair_cnt_o >= $past(repair_cnt_o));

    p_fail_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !pass_o) |-> fail_phase_o != 2'd3);
endmodule

bind eprom_burn_seq eprom_burn_seq_chk #(
    .ADDR_W    (ADDR_W),
    .CLK_HZ    (CLK_HZ),
    .PULSE_US  (PULSE_US),
    .SETTLE_CYC(SETTLE_CYC),
    .CNT_W     (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pgm_o       (pgm_o),
    .vsel_o      (vsel_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .fail_addr_o (fail_addr_o),
    .fail_phase_o(fail_phase_o),
    .repair_cnt_o(repair_cnt_o)
);

// File: tb/eprom_burn_seq_tb_top.sv
module eprom_burn_seq_tb_top;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PULSE_CYC  = 100;
    localparam int SETTLE_CYC = 6;
    localparam int ACCESS_CYC = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] src_data, wdata, rdata;
    logic              pgm, busy, done, pass;
    logic [1:0]        vsel, fph;
    logic [ADDR_W-1:0] faddr;
    logic [15:0]       rep;

    always #2 clk = ~clk;

    eprom_burn_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .addr_o(addr), .src_data_i(src_data), .wdata_o(wdata), .rdata_i(rdata),
        .pgm_o(pgm), .vsel_o(vsel), .busy_o(busy), .done_o(done), .pass_o(pass),
        .fail_addr_o(faddr), .fail_phase_o(fph), .repair_cnt_o(rep)
    );

    // Behavioural device and source buffer
    logic [DATA_W-1:0] img [DEPTH];
    int  need   [DEPTH];
    bit  lowf   [DEPTH];
    bit  highf  [DEPTH];
    int  pulses [DEPTH];
    int  plog   [DEPTH];
    int  pcount, viol_lvl, viol_wid, viol_set;
    int  astab, vstab, wcnt;
    logic [ADDR_W-1:0] aprev;
    logic [1:0] vprev;
    logic pprev;
    logic ok;

    int tests = 0, fails = 0;

    assign src_data = img[addr];

    always_comb begin
        ok = 1'b0;
        rdata = ~img[addr];
        if (vsel != 2'b00 && astab >= ACCESS_CYC - 1 && vstab >= SETTLE_CYC - 1) begin
            ok = (pulses[addr] >= need[addr]);
            if (vsel == 2'b10 && lowf[addr])  ok = 1'b0;
            if (vsel == 2'b11 && highf[addr]) ok = 1'b0;
            if (ok) rdata = img[addr];
        end
    end

    always @(negedge clk) begin
        if (addr !== aprev) astab <= 0; else if (astab < 1000) astab <= astab + 1;
        if (vsel !== vprev) vstab = 0; else if (vstab < 1000) vstab = vstab + 1;
        aprev <= addr;
        vprev <= vsel;
        if (pgm && !pprev) begin
            pulses[addr] <= pulses[addr] + 1;
            if (pcount < DEPTH) plog[pcount] <= int'(addr);
            pcount <= pcount + 1;
            if (vstab < SETTLE_CYC) viol_set <= viol_set + 1;
            wcnt <= 1;
        end else if (pgm) begin
            wcnt <= wcnt + 1;
        end
        if (pgm && vsel != 2'b01) viol_lvl <= viol_lvl + 1;
        if (!pgm && pprev && wcnt != PULSE_CYC) viol_wid <= viol_wid + 1;
        if (pgm && wdata != img[addr]) viol_lvl <= viol_lvl + 1;
        pprev <= pgm;
    end

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int a = 0; a < DEPTH; a++) begin
            pulses[a] = 0;
            plog[a]   = -1;
        end
        pcount = 0; viol_lvl = 0; viol_wid = 0; viol_set = 0;
    endtask

    task automatic expect_result(output bit ep, output int ea, output int eph, output int erep);
        ep = 1'b1; ea = 0; eph = 0; erep = 0;
        for (int a = 0; a < DEPTH; a++) begin
            if (need[a] > 11) begin
                erep += 10; ep = 1'b0; ea = a; eph = 0;
                return;
            end
            erep += need[a] - 1;
        end
        for (int a = 0; a < DEPTH; a++)
            if (lowf[a]) begin ep = 1'b0; ea = a; eph = 1; return; end
        for (int a = 0; a < DEPTH; a++)
            if (highf[a]) begin ep = 1'b0; ea = a; eph = 2; return; end
    endtask

    task automatic run_case(input string name, input bit inject);
        bit ep; int ea, eph, erep; int cyc; bit order_ok;
        expect_result(ep, ea, eph, erep);
        clear_model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy && !done, "R1 start accepted", {busy, done}, 2);
        cyc = 0;
        while (!done && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (inject && cyc == 300) start = 1'b1;
            if (inject && cyc == 301) start = 1'b0;
        end
        chk(cyc < 40000, "R1 run completes", cyc, 40000);
        chk(pass == ep, "R6 pass flag", pass, ep);
        if (!ep) begin
            chk(int'(faddr) == ea, "R5 fail address", faddr, ea);
            chk(int'(fph) == eph, "R6 fail phase", fph, eph);
        end
        chk(int'(rep) == erep, "R9 repair count", rep, erep);
        chk(pcount == DEPTH + erep, "R4 total pulses", pcount, DEPTH + erep);
        order_ok = 1'b1;
        for (int k = 0; k < DEPTH; k++) if (plog[k] != k) order_ok = 1'b0;
        chk(order_ok, "R2 first-stage order", order_ok, 1);
        chk(viol_lvl == 0 && viol_wid == 0, "R3 pulse level and width",
            viol_lvl + viol_wid, 0);
        chk(viol_set == 0, "R7 settle before pulse", viol_set, 0);
        chk(vsel == 2'b00 && !pgm, "R10 idle level", vsel, 0);
        repeat (20) @(negedge clk);
        chk(done && pass == ep && int'(rep) == erep, "R1 result held", pass, ep);
        $display("[TB] case %s done", name);
    endtask

    task automatic base_image(input int seed_off);
        for (int a = 0; a < DEPTH; a++) begin
            img[a]   = DATA_W'($urandom_range(0, 255));
            need[a]  = 1;
            lowf[a]  = 1'b0;
            highf[a] = 1'b0;
        end
        if (seed_off < 0) img[0] = '0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        base_image(0);
        clear_model();
        astab = 0; vstab = 0; wcnt = 0; aprev = '0; vprev = 2'b00; pprev = 1'b0;
        repeat (5) @(negedge clk);
        chk(!busy && !done && !pass && vsel == 2'b00, "R10 reset state",
            {busy, done, pass}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        base_image(0);
        run_case("clean", 1'b0);                        // R2 R4

        base_image(0); need[1] = 11;
        run_case("repair at limit", 1'b0);              // R5 boundary: exactly 10

        base_image(0); need[2] = 3; need[5] = 12;
        run_case("repair exhausted", 1'b0);             // R5

        base_image(0); lowf[3] = 1'b1; highf[2] = 1'b1;
        run_case("low corner first", 1'b0);             // R6 ordering

        base_image(0); highf[15] = 1'b1;
        run_case("high corner last address", 1'b0);     // R6

        base_image(0); need[0] = 4; need[15] = 2;
        run_case("start while busy", 1'b1);             // R1, R8 via reads

        for (int r = 0; r < 8; r++) begin
            base_image(0);
            for (int a = 0; a < DEPTH; a++) begin
                int p;
                p = $urandom_range(0, 99);
                need[a] = (p < 60) ? 1 : (p < 97) ? $urandom_range(2, 6) : 12;
                lowf[a]  = ($urandom_range(0, 99) < 2);
                highf[a] = ($urandom_range(0, 99) < 2);
            end
            run_case("random", 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule